// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block executes the control-flow instructions of an 8-bit processor that has a 16-bit program counter and a 16-bit stack pointer. The block samples an opcode together with the current PC, SP, HL and flag byte. It tests the condition code the opcode names and then fetches any operand bytes. Stack pushes and pops go through a byte-wide memory port, one access per clock. When the instruction is finished the block presents the new PC and SP.

The handled group is: relative jumps, absolute jumps, jump through HL, the eight restart vectors, calls, returns and the interrupt return. The interrupt return also raises a one-cycle pulse that tells the core to re-enable interrupts. Opcode fetch and interrupt dispatch stay with the surrounding core. The core hands over an opcode with a start pulse and waits for the done strobe.

The memory port is combinational on reads: the byte at `mem_addr` must be on `mem_rdata` in the same cycle. A write takes effect on the clock edge that ends a cycle in which `mem_req` and `mem_we` are both high.

Top module: `flow_seq`

## Requirements
- R1: After a synchronous reset, `pc_out`, `sp_out`, `done`, `ime_set`, `busy` and `mem_req` are all zero.
- R2: For conditional forms, opcode bits 4:3 select the condition: 00 = Z clear, 01 = Z set, 10 = C clear, 11 = C set. Z is flag bit 7 and C is flag bit 4. The other flag bits have no effect.
- R3: The relative jump (0x18 always; 0x20, 0x28, 0x30 and 0x38 conditional) reads a signed byte at PC+1. When taken, PC becomes PC+2+offset, modulo 2^16. When not taken, PC becomes PC+2 and no memory access is made.
- R4: The absolute jump (0xC3 always; 0xC2, 0xCA, 0xD2 and 0xDA conditional) reads the target low byte at PC+1 and the high byte at PC+2. When not taken, PC becomes PC+3 and no access is made.
- R5: Opcode 0xE9 sets PC to HL and makes no memory access.
- R6: A restart opcode (bits 7:6 = 11, bits 2:0 = 111) pushes PC+1 and sets PC to bits 5:3 of the opcode times 8.
- R7: A push writes the return-address high byte to SP-1 and then writes the low byte to SP-2 on the next cycle. SP is then decreased by 2, modulo 2^16.
- R8: A call (0xCD always; 0xC4, 0xCC, 0xD4 and 0xDC conditional) reads a target the same way as R4, pushes PC+3 and jumps to the target. When not taken, PC becomes PC+3, SP is unchanged and nothing is written.
- R9: A return (0xC9 always; 0xC0, 0xC8, 0xD0 and 0xD8 conditional) reads the low byte at SP, then the high byte at SP+1, and increases SP by 2. When not taken, PC becomes PC+1, SP is unchanged and no access is made.
- R10: Opcode 0xD9 always returns as in R9 and pulses `ime_set` in the same cycle as `done`. No other opcode pulses `ime_set`.
- R11: There is at most one memory access per cycle. `done` is a one-cycle pulse that comes with the updated `pc_out` and `sp_out`. `pc_out` changes only then. A `start` pulse while `busy` is high is ignored.
- R12: Any other opcode completes with PC+1, SP unchanged and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `opcode` (sampled while idle) |
| opcode | input | 8 | Instruction byte |
| pc_in | input | 16 | Address of the instruction |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | Current HL pair |
| flags_in | input | 8 | Current flag byte |
| mem_rdata | input | 8 | Read data for `mem_addr`, same cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 16 | Updated stack pointer |
| ime_set | output | 1 | Interrupt-enable set pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |

## Verification
The bench builds the block with its default 8-bit data path, which gives 16-bit addresses. Against a full 64 KiB byte memory, this lets the bench sweep every relative offset, all sixteen values of the flag nibble for every conditional opcode, and all eight restart vectors. The full address range also brings within reach the wrap cases: a relative jump below zero and a push that crosses the bottom of memory. The bench also checks the access count of every instruction, which exposes any surplus or missing operand or stack cycle.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int DW        = 8;
    localparam int AW        = 2 * DW;
    localparam int VEC_SHIFT = 3;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        K_OTHER, K_JREL, K_JABS, K_JIND, K_VEC, K_CALL, K_RET, K_RETI
    } kind_e;

    typedef enum logic [2:0] {
        CC_ALWAYS, CC_NZ, CC_Z, CC_NC, CC_C
    } cond_e;

    typedef struct packed {
        kind_e kind;
        cond_e cond;
        logic  taken;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPLO, ST_OPHI, ST_PUSHHI, ST_PUSHLO, ST_POPLO, ST_POPHI, ST_FIN
    } state_e;

    function automatic cond_e cc_field(input logic [1:0] cc);
        case (cc)
            2'b00:   return CC_NZ;
            2'b01:   return CC_Z;
            2'b10:   return CC_NC;
            default: return CC_C;
        endcase
    endfunction

    function automatic addr_t vec_addr(input byte_t op);
        return addr_t'(op[5:3]) << VEC_SHIFT;
    endfunction

    function automatic state_e entry_state(input dec_t d);
        case (d.kind)
            K_JREL, K_JABS, K_CALL: return d.taken ? ST_OPLO : ST_FIN;
            K_VEC:                  return ST_PUSHHI;
            K_RET, K_RETI:          return d.taken ? ST_POPLO : ST_FIN;
            default:                return ST_FIN;
        endcase
    endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
#(
    parameter int ZF_BIT = 7,
    parameter int CF_BIT = 4
) (
    input  byte_t opcode,
    input  byte_t flags,
    output dec_t  dec
);

    kind_e kind;
    cond_e cond;
    logic  met;

    always_comb begin
        kind = K_OTHER;
        cond = CC_ALWAYS;
        if (opcode == 8'h18) begin
            kind = K_JREL;
        end else if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
            kind = K_JREL;
            cond = cc_field(opcode[4:3]);
        end else if (opcode[7:6] == 2'b11) begin
            if (opcode == 8'hC3)             kind = K_JABS;
            else if (opcode == 8'hCD)        kind = K_CALL;
            else if (opcode == 8'hC9)        kind = K_RET;
            else if (opcode == 8'hD9)        kind = K_RETI;
            else if (opcode == 8'hE9)        kind = K_JIND;
            else if (opcode[2:0] == 3'b111)  kind = K_VEC;
            else if (opcode[5] == 1'b0) begin
                case (opcode[2:0])
                    3'b010: begin kind = K_JABS; cond = cc_field(opcode[4:3]); end
                    3'b100: begin kind = K_CALL; cond = cc_field(opcode[4:3]); end
                    3'b000: begin kind = K_RET;  cond = cc_field(opcode[4:3]); end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (cond)
            CC_NZ:   met = ~flags[ZF_BIT];
            CC_Z:    met =  flags[ZF_BIT];
            CC_NC:   met = ~flags[CF_BIT];
            CC_C:    met =  flags[CF_BIT];
            default: met = 1'b1;
        endcase
    end

    assign dec = '{kind: kind, cond: cond, taken: met};

endmodule

// File: rtl/flow_addr.sv
module flow_addr
    import flow_pkg::*;
(
    input  dec_t  dec,
    input  byte_t op,
    input  addr_t pc,
    input  addr_t sp,
    input  addr_t hl,
    input  byte_t lo,
    input  byte_t hi,
    output addr_t nxt_pc,
    output addr_t nxt_sp,
    output addr_t ret_addr
);

    addr_t opnd, pc1, pc2, pc3, rel;

    always_comb begin
        opnd = {hi, lo};
        pc1  = pc + addr_t'(1);
        pc2  = pc + addr_t'(2);
        pc3  = pc + addr_t'(3);
        rel  = pc2 + {{DW{lo[DW-1]}}, lo};
    end

    always_comb begin
        nxt_pc   = pc1;
        nxt_sp   = sp;
        ret_addr = pc3;
        case (dec.kind)
            K_JREL: nxt_pc = dec.taken ? rel : pc2;
            K_JABS: nxt_pc = dec.taken ? opnd : pc3;
            K_JIND: nxt_pc = hl;
            K_VEC: begin
                nxt_pc   = vec_addr(op);
                nxt_sp   = sp - addr_t'(2);
                ret_addr = pc1;
            end
            K_CALL: begin
                nxt_pc = dec.taken ? opnd : pc3;
                nxt_sp = dec.taken ? sp - addr_t'(2) : sp;
            end
            K_RET: begin
                nxt_pc = dec.taken ? opnd : pc1;
                nxt_sp = dec.taken ? sp + addr_t'(2) : sp;
            end
            K_RETI: begin
                nxt_pc = opnd;
                nxt_sp = sp + addr_t'(2);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int ZF_BIT = 7,
    parameter int CF_BIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [15:0] pc_in,
    input  logic [15:0] sp_in,
    input  logic [15:0] hl_in,
    input  logic [7:0]  flags_in,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic        ime_set,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata
);

    state_e st_q, st_d;
    dec_t   dec_now, dec_q;
    byte_t  op_q, lo_q, hi_q;
    addr_t  pc_l, sp_l, hl_l;
    addr_t  pc_q, sp_q;
    addr_t  nxt_pc, nxt_sp, ret_addr;
    logic   done_q, ime_q;

    flow_decode #(.ZF_BIT(ZF_BIT), .CF_BIT(CF_BIT)) u_decode (
        .opcode (opcode),
        .flags  (flags_in),
        .dec    (dec_now)
    );

    flow_addr u_addr (
        .dec      (dec_q),
        .op       (op_q),
        .pc       (pc_l),
        .sp       (sp_l),
        .hl       (hl_l),
        .lo       (lo_q),
        .hi       (hi_q),
        .nxt_pc   (nxt_pc),
        .nxt_sp   (nxt_sp),
        .ret_addr (ret_addr)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:   if (start) st_d = entry_state(dec_now);
            ST_OPLO:   st_d = (dec_q.kind == K_JREL) ? ST_FIN : ST_OPHI;
            ST_OPHI:   st_d = (dec_q.kind == K_CALL) ? ST_PUSHHI : ST_FIN;
            ST_PUSHHI: st_d = ST_PUSHLO;
            ST_PUSHLO: st_d = ST_FIN;
            ST_POPLO:  st_d = ST_POPHI;
            ST_POPHI:  st_d = ST_FIN;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q)
            ST_OPLO:   begin mem_req = 1'b1; mem_addr = pc_l + addr_t'(1); end
            ST_OPHI:   begin mem_req = 1'b1; mem_addr = pc_l + addr_t'(2); end
            ST_PUSHHI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_l - addr_t'(1);
                mem_wdata = ret_addr[AW-1:DW];
            end
            ST_PUSHLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_l - addr_t'(2);
                mem_wdata = ret_addr[DW-1:0];
            end
            ST_POPLO:  begin mem_req = 1'b1; mem_addr = sp_l; end
            ST_POPHI:  begin mem_req = 1'b1; mem_addr = sp_l + addr_t'(1); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            dec_q  <= '{kind: K_OTHER, cond: CC_ALWAYS, taken: 1'b0};
            op_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pc_l   <= '0;
            sp_l   <= '0;
            hl_l   <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            done_q <= 1'b0;
            ime_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            ime_q  <= 1'b0;
            if (st_q == ST_IDLE && start) begin
                dec_q <= dec_now;
                op_q  <= opcode;
                pc_l  <= pc_in;
                sp_l  <= sp_in;
                hl_l  <= hl_in;
            end
            if (st_q == ST_OPLO || st_q == ST_POPLO) lo_q <= mem_rdata;
            if (st_q == ST_OPHI || st_q == ST_POPHI) hi_q <= mem_rdata;
            if (st_q == ST_FIN) begin
                pc_q   <= nxt_pc;
                sp_q   <= nxt_sp;
                done_q <= 1'b1;
                ime_q  <= (dec_q.kind == K_RETI);
            end
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign ime_set = ime_q;
    assign pc_out  = pc_q;
    assign sp_out  = sp_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R11

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> pc_out == $past(pc_out)); // R11

    AST_IME_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ime_set |-> done); // R10

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == $past(mem_addr) - 16'd1)); // R7

    AST_POP_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_POPLO) |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + 16'd1)); // R9

    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        done |-> (sp_out == sp_l || sp_out == sp_l - 16'd2 || sp_out == sp_l + 16'd2)); // R7

endmodule

// File: tb/test_flow_seq.sv
module test_flow_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  opcode;
    logic [15:0] pc_in, sp_in, hl_in;
    logic [7:0]  flags_in;
    logic [7:0]  mem_rdata;
    logic        busy, done, ime_set, mem_req, mem_we;
    logic [15:0] pc_out, sp_out, mem_addr;
    logic [7:0]  mem_wdata;

    logic [7:0]  mem [0:65535];
    int          n_rd, n_wr;
    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] r_pc, r_sp;
    logic        r_ime;
    int          r_rd, r_wr;

    always #2.5 clk = ~clk;

    flow_seq i_flow_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in), .flags_in(flags_in),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out),
        .sp_out(sp_out), .ime_set(ime_set), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic cond_ok(input logic [1:0] cc, input logic [7:0] f);
        case (cc)
            2'd0: return !f[7];
            2'd1: return  f[7];
            2'd2: return !f[4];
            default: return f[4];
        endcase
    endfunction

    // Issue one instruction; optionally pulse start again while busy.
    task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] sp,
                       input logic [15:0] hl, input logic [7:0] fl, input logic poke);
        int wait_cnt;
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        opcode = op; pc_in = pc; sp_in = sp; hl_in = hl; flags_in = fl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            opcode = 8'hE9; hl_in = 16'h7777; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (!done && wait_cnt < 32) begin
            @(negedge clk);
            wait_cnt++;
        end
        if (!done) begin
            n_err++;
            $display("FAIL R11 done never seen for opcode %h", op);
        end
        r_pc = pc_out; r_sp = sp_out; r_ime = ime_set; r_rd = n_rd; r_wr = n_wr;
        @(negedge clk);
        chk("R11", "done is a single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic expect_res(input string req, input logic [15:0] epc, input logic [15:0] esp,
                              input logic eime, input int erd, input int ewr);
        chk(req, "pc", {16'd0, r_pc}, {16'd0, epc});
        chk(req, "sp", {16'd0, r_sp}, {16'd0, esp});
        chk("R10", "ime_set", {31'd0, r_ime}, {31'd0, eime});
        chk(req, "reads", r_rd, erd);
        chk(req, "writes", r_wr, ewr);
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL R11 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] jr_ops [5];
        logic [7:0] jp_ops [5];
        logic [7:0] call_ops [5];
        logic [7:0] ret_ops [5];
        logic [7:0] other_ops [7];
        jr_ops   = '{8'h18, 8'h20, 8'h28, 8'h30, 8'h38};
        jp_ops   = '{8'hC3, 8'hC2, 8'hCA, 8'hD2, 8'hDA};
        call_ops = '{8'hCD, 8'hC4, 8'hCC, 8'hD4, 8'hDC};
        ret_ops  = '{8'hC9, 8'hC0, 8'hC8, 8'hD0, 8'hD8};
        other_ops = '{8'h00, 8'h3E, 8'h76, 8'hC1, 8'hD3, 8'hE2, 8'hFA};
        for (int a = 0; a < 65536; a++) mem[a] = 8'h00;

        rst = 1'b1; start = 1'b0; opcode = '0; pc_in = '0; sp_in = '0; hl_in = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "pc_out", {16'd0, pc_out}, 32'd0);
        chk("R1", "sp_out", {16'd0, sp_out}, 32'd0);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "ime_set", {31'd0, ime_set}, 32'd0);
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);

        // R2 R3: relative jumps over every flag nibble (low nibble junk)
        mem[16'h1235] = 8'hF0;
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] fl;
                logic tk;
                fl = {f[3:0], 4'hA};
                tk = (k == 0) ? 1'b1 : cond_ok(2'(k - 1), fl);
                run(jr_ops[k], 16'h1234, 16'h0300, 16'h0, fl, 1'b0);
                expect_res("R3", tk ? 16'h1226 : 16'h1236, 16'h0300, 1'b0, tk ? 1 : 0, 0);
            end
        end
        // R3: every offset, including a wrap below zero
        for (int o = 0; o < 256; o++) begin
            logic [7:0] ob;
            ob = o[7:0];
            mem[16'h0041] = ob;
            run(8'h18, 16'h0040, 16'h0300, 16'h0, 8'h00, 1'b0);
            expect_res("R3", 16'h0042 + {{8{ob[7]}}, ob}, 16'h0300, 1'b0, 1, 0);
        end

        // R2 R4: absolute jumps
        mem[16'h2001] = 8'hEF; mem[16'h2002] = 8'hBE;
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] fl;
                logic tk;
                fl = {f[3:0], 4'h5};
                tk = (k == 0) ? 1'b1 : cond_ok(2'(k - 1), fl);
                run(jp_ops[k], 16'h2000, 16'h0300, 16'h0, fl, 1'b0);
                expect_res("R4", tk ? 16'hBEEF : 16'h2003, 16'h0300, 1'b0, tk ? 2 : 0, 0);
            end
        end

        // R5: jump through HL
        run(8'hE9, 16'h3000, 16'h0300, 16'h8421, 8'hF0, 1'b0);
        expect_res("R5", 16'h8421, 16'h0300, 1'b0, 0, 0);
        run(8'hE9, 16'h3000, 16'h0300, 16'hFFFF, 8'h00, 1'b0);
        expect_res("R5", 16'hFFFF, 16'h0300, 1'b0, 0, 0);

        // R6 R7: all restart vectors
        for (int v = 0; v < 8; v++) begin
            mem[16'h01FE] = 8'h55; mem[16'h01FF] = 8'h55;
            run(8'hC7 | 8'(v << 3), 16'h0101, 16'h0200, 16'h0, 8'h00, 1'b0);
            expect_res("R6", 16'(v * 8), 16'h01FE, 1'b0, 0, 2);
            chk("R7", "pushed high byte", {24'd0, mem[16'h01FF]}, 32'h01);
            chk("R7", "pushed low byte", {24'd0, mem[16'h01FE]}, 32'h02);
        end
        // R7: push across the bottom of memory
        run(8'hFF, 16'h0A10, 16'h0001, 16'h0, 8'h00, 1'b0);
        expect_res("R7", 16'h0038, 16'hFFFF, 1'b0, 0, 2);
        chk("R7", "wrap high byte", {24'd0, mem[16'h0000]}, 32'h0A);
        chk("R7", "wrap low byte", {24'd0, mem[16'hFFFF]}, 32'h11);

        // R2 R8: calls
        mem[16'h0101] = 8'h21; mem[16'h0102] = 8'h43;
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] fl;
                logic tk;
                fl = {f[3:0], 4'h3};
                tk = (k == 0) ? 1'b1 : cond_ok(2'(k - 1), fl);
                mem[16'h01FE] = 8'hEE; mem[16'h01FF] = 8'hEE;
                run(call_ops[k], 16'h0100, 16'h0200, 16'h0, fl, 1'b0);
                expect_res("R8", tk ? 16'h4321 : 16'h0103, tk ? 16'h01FE : 16'h0200, 1'b0,
                           tk ? 2 : 0, tk ? 2 : 0);
                chk("R8", "stack high", {24'd0, mem[16'h01FF]}, tk ? 32'h01 : 32'hEE);
                chk("R8", "stack low", {24'd0, mem[16'h01FE]}, tk ? 32'h03 : 32'hEE);
            end
        end

        // R2 R9: returns
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] fl;
                logic tk;
                fl = {f[3:0], 4'hC};
                tk = (k == 0) ? 1'b1 : cond_ok(2'(k - 1), fl);
                mem[16'h01FE] = 8'hBC; mem[16'h01FF] = 8'h9A;
                run(ret_ops[k], 16'h0100, 16'h01FE, 16'h0, fl, 1'b0);
                expect_res("R9", tk ? 16'h9ABC : 16'h0101, tk ? 16'h0200 : 16'h01FE, 1'b0,
                           tk ? 2 : 0, 0);
            end
        end

        // R10: interrupt return, with any flags
        mem[16'h01FE] = 8'h34; mem[16'h01FF] = 8'h12;
        run(8'hD9, 16'h0100, 16'h01FE, 16'h0, 8'h00, 1'b0);
        expect_res("R10", 16'h1234, 16'h0200, 1'b1, 2, 0);
        run(8'hD9, 16'h0100, 16'h01FE, 16'h0, 8'hF0, 1'b0);
        expect_res("R10", 16'h1234, 16'h0200, 1'b1, 2, 0);

        // R12: non-control opcodes
        for (int k = 0; k < 7; k++) begin
            run(other_ops[k], 16'h5000, 16'h0400, 16'h1111, 8'hF0, 1'b0);
            expect_res("R12", 16'h5001, 16'h0400, 1'b0, 0, 0);
        end

        // R11: start while busy is ignored
        mem[16'h0101] = 8'h21; mem[16'h0102] = 8'h43;
        run(8'hCD, 16'h0100, 16'h0200, 16'h0, 8'h00, 1'b1);
        expect_res("R11", 16'h4321, 16'h01FE, 1'b0, 2, 2);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule